// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside an 8-bit processor core, between the core's instruction sequencer and the interrupt pending and enable registers. Whenever the core reaches an instruction boundary it raises a one-cycle strobe. At that moment it also presents the address of the next instruction, the current stack pointer, the cost of the finished instruction in T-cycles, the state of its global interrupt enable, the pending byte and the per-source enable bits. If the global enable is set and at least one of the five sources is both pending and enabled, the block takes the lowest-numbered one. It then runs a fixed five-M-cycle entry: it writes the pending byte back with only that bit cleared, tells the core to drop its global enable, stores the return address on the stack as two bytes, hands back the lowered stack pointer and loads the program counter with the source's vector.

The block is clocked at one edge per M-cycle. Its controller has six states. ST_IDLE waits for a boundary. ST_ACK writes back the pending byte and clears the global enable. ST_GAP is an internal cycle with no bus activity. ST_PUSH_HI writes the high return byte, ST_PUSH_LO writes the low return byte and the new stack pointer, and ST_JUMP loads the vector. The transitions are fixed. IDLE goes to ACK on a boundary that finds an enabled pending source; any other boundary leaves the block in IDLE. ACK goes to GAP, GAP to PUSH_HI, PUSH_HI to PUSH_LO, PUSH_LO to JUMP, and JUMP back to IDLE, each unconditionally. One cycle after every accepted boundary the block reports the total cost of the boundary: the instruction's T-cycles, plus 20 when an entry was started. The core must not fetch while the busy output is high.

Top module: `irq_dispatcher`

## Requirements
- R1: When the global enable input is low at a boundary, no entry starts. For that boundary, busy, the write strobes, the stack writes and the program-counter load all stay low, and the reported total equals the instruction's cycles.
- R2: Candidate sources are bits 0 to 4 of the pending byte ANDed with the 5-bit enable input. Pending bits 5 to 7 never start an entry. With no candidate, no entry starts and the total equals the instruction's cycles.
- R3: Among several candidates, the one with the lowest bit number is serviced.
- R4: The vector loaded for source n is 0x40 + 8*n, which gives 0x40, 0x48, 0x50, 0x58 and 0x60.
- R5: In the first busy cycle, the pending write strobe is high. The written byte equals the sampled pending byte with only the serviced bit cleared, so bits 5 to 7 and the other sources are unchanged.
- R6: The global-enable clear output pulses in the first busy cycle, together with the pending write.
- R7: In the third busy cycle, the stack write carries the high byte of the sampled program counter to address SP-1. In the fourth busy cycle, it carries the low byte to SP-2, and the stack-pointer write presents SP-2. Address arithmetic wraps modulo 2^16.
- R8: In the fifth busy cycle, the program-counter load pulses with the vector. The pushed address is the program counter sampled at the boundary.
- R9: Busy is high for exactly five cycles, starting in the cycle after the boundary.
- R10: The total-valid strobe pulses one cycle after each boundary taken in idle. The total equals the instruction's cycles plus 20 if an entry started.
- R11: A boundary strobe that arrives while busy is ignored. It produces no total-valid pulse and does not disturb the running entry.
- R12: After reset, busy and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | M-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| ime_in | input | 1 | Core's global interrupt enable |
| flags_in | input | 8 | Pending byte |
| enable_in | input | 5 | Per-source enable bits |
| pc_in | input | 16 | Address of the next instruction |
| sp_in | input | 16 | Current stack pointer |
| inst_cycles | input | 8 | T-cycles of the finished instruction |
| flags_wr | output | 1 | Pending byte write strobe |
| flags_out | output | 8 | Pending byte to write |
| ime_clr | output | 1 | Clear global enable |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | 16 | Stack byte address |
| stk_data | output | 8 | Stack byte data |
| sp_wr | output | 1 | Stack pointer write strobe |
| sp_out | output | 16 | New stack pointer |
| pc_ld | output | 1 | Program counter load strobe |
| pc_out | output | 16 | Vector to load |
| busy | output | 1 | Entry sequence in progress |
| total_valid | output | 1 | Cycle report strobe |
| total_cycles | output | 8 | Cycles for the boundary, entry included |

## Verification
The bench mixes seeded random boundaries with directed corners: every single source alone, all five sources pending together, candidates that exist only in bits 5 to 7, enables that mask every pending bit, a clear global enable with everything pending, and a stack pointer of 0x0001 so that the push wraps. A priority encoder that favoured the top bit, or that let bits 5 to 7 through, would load the wrong vector or start a spurious entry. A write-back that cleared a whole mask would lose other pending bits. Swapped push bytes, or a skipped internal cycle, would show up in the address, data and timing of the stack writes. Boundary strobes injected during busy catch a controller that restarts or re-reports.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC_D   = 5;
    localparam int FLAG_W_D    = 8;
    localparam int ADDR_W_D    = 16;
    localparam int CYC_W_D     = 8;
    localparam int VEC_BASE_D  = 'h40;
    localparam int VEC_STEP_D  = 8;
    localparam int ENTRY_MCYC  = 5;
    localparam int T_PER_M     = 4;
    localparam int ENTRY_T     = ENTRY_MCYC * T_PER_M;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACK     = 3'd1,
        ST_GAP     = 3'd2,
        ST_PUSH_HI = 3'd3,
        ST_PUSH_LO = 3'd4,
        ST_JUMP    = 3'd5
    } disp_state_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 5,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               valid
);

    logic [NUM_SRC:0] seen;
    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_chain
            assign grant[g]  = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate

    assign valid = seen[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    // R3
    always_comb begin
        if (!$isunknown(req)) begin
            grant_onehot_chk: assert ($onehot0(grant) && (valid == (req != '0)));
        end
    end

endmodule

// File: rtl/irq_vector_map.sv
module irq_vector_map #(
    parameter int NUM_SRC  = 5,
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 'h40,
    parameter int VEC_STEP = 8,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] vec
);

    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(VEC_STEP);

    always_comb begin
        vec = BASE_V + (ADDR_W'(idx) * STEP_V);
    end

endmodule

// File: rtl/irq_cycle_acct.sv
module irq_cycle_acct #(
    parameter int CYC_W   = 8,
    parameter int ENTRY_T = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             take,
    input  logic [CYC_W-1:0] inst_cycles,
    output logic             total_valid,
    output logic [CYC_W-1:0] total_cycles
);

    localparam logic [CYC_W-1:0] ENTRY_V = CYC_W'(ENTRY_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_valid  <= 1'b0;
            total_cycles <= '0;
        end else begin
            total_valid <= accept;
            if (accept) begin
                total_cycles <= inst_cycles + (take ? ENTRY_V : '0);
            end
        end
    end

endmodule

// File: rtl/irq_dispatcher.sv
module irq_dispatcher
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = NUM_SRC_D,
    parameter int FLAG_W   = FLAG_W_D,
    parameter int ADDR_W   = ADDR_W_D,
    parameter int CYC_W    = CYC_W_D,
    parameter int VEC_BASE = VEC_BASE_D,
    parameter int VEC_STEP = VEC_STEP_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              ime_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [NUM_SRC-1:0] enable_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [CYC_W-1:0]  inst_cycles,
    output logic              flags_wr,
    output logic [FLAG_W-1:0] flags_out,
    output logic              ime_clr,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [7:0]        stk_data,
    output logic              sp_wr,
    output logic [ADDR_W-1:0] sp_out,
    output logic              pc_ld,
    output logic [ADDR_W-1:0] pc_out,
    output logic              busy,
    output logic              total_valid,
    output logic [CYC_W-1:0]  total_cycles
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int VEC_LAST = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

    disp_state_e state_q, state_d;

    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_valid;
    logic               accept;
    logic               take;

    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  pc_q;
    logic [ADDR_W-1:0]  sp_q;
    logic [FLAG_W-1:0]  flags_q;
    logic [ADDR_W-1:0]  vec;

    assign cand   = flags_in[NUM_SRC-1:0] & enable_in;
    assign accept = (state_q == ST_IDLE) && boundary;
    assign take   = accept && ime_in && pick_valid;

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req   (cand),
        .grant (grant),
        .idx   (pick_idx),
        .valid (pick_valid)
    );

    irq_vector_map #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) u_vec (
        .idx (idx_q),
        .vec (vec)
    );

    irq_cycle_acct #(.CYC_W(CYC_W), .ENTRY_T(ENTRY_T)) u_acct (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .take         (take),
        .inst_cycles  (inst_cycles),
        .total_valid  (total_valid),
        .total_cycles (total_cycles)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take) state_d = ST_ACK;
            ST_ACK:     state_d = ST_GAP;
            ST_GAP:     state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_JUMP;
            ST_JUMP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Snapshot of the boundary context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            flags_q <= '0;
        end else if (take) begin
            idx_q   <= pick_idx;
            pc_q    <= pc_in;
            sp_q    <= sp_in;
            flags_q <= flags_in & ~FLAG_W'(grant);
        end
    end

    // Outputs per state
    always_comb begin
        flags_wr  = 1'b0;
        flags_out = flags_q;
        ime_clr   = 1'b0;
        stk_we    = 1'b0;
        stk_addr  = '0;
        stk_data  = '0;
        sp_wr     = 1'b0;
        sp_out    = sp_q - ADDR_W'(2);
        pc_ld     = 1'b0;
        pc_out    = vec;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_ACK: begin
                flags_wr = 1'b1;
                ime_clr  = 1'b1;
            end
            ST_GAP: begin
                busy = 1'b1;
            end
            ST_PUSH_HI: begin
                stk_we   = 1'b1;
                stk_addr = sp_q - ADDR_W'(1);
                stk_data = pc_q[ADDR_W-1 -: 8];
            end
            ST_PUSH_LO: begin
                stk_we   = 1'b1;
                stk_addr = sp_q - ADDR_W'(2);
                stk_data = pc_q[7:0];
                sp_wr    = 1'b1;
            end
            ST_JUMP: begin
                pc_ld = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R1
    no_entry_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && boundary && !ime_in) |=> !busy);

    // R9
    entry_starts_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (flags_wr && ime_clr));

    // R9
    jump_ends_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |=> !busy);

    // R7
    stack_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |-> busy);

    // R8
    push_before_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |-> $past(stk_we));

    // R4
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |-> (pc_out >= ADDR_W'(VEC_BASE) && pc_out <= ADDR_W'(VEC_LAST)));

    // R5
    upper_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_wr |-> (flags_out[FLAG_W-1:NUM_SRC] == $past(flags_in[FLAG_W-1:NUM_SRC])));

    // R11
    no_report_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> !total_valid);

endmodule

// File: tb/test_irq_dispatcher.sv
`timescale 1ns/1ps
module test_irq_dispatcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        ime_in = 1'b0;
    logic [7:0]  flags_in = '0;
    logic [4:0]  enable_in = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] sp_in = '0;
    logic [7:0]  inst_cycles = '0;
    logic        flags_wr, ime_clr, stk_we, sp_wr, pc_ld, busy, total_valid;
    logic [7:0]  flags_out, stk_data, total_cycles;
    logic [15:0] stk_addr, sp_out, pc_out;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_dispatcher i_irq_dispatcher (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .ime_in(ime_in),
        .flags_in(flags_in), .enable_in(enable_in), .pc_in(pc_in), .sp_in(sp_in),
        .inst_cycles(inst_cycles), .flags_wr(flags_wr), .flags_out(flags_out),
        .ime_clr(ime_clr), .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data),
        .sp_wr(sp_wr), .sp_out(sp_out), .pc_ld(pc_ld), .pc_out(pc_out), .busy(busy),
        .total_valid(total_valid), .total_cycles(total_cycles)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_idx(input logic [7:0] f, input logic [4:0] en);
        for (int i = 0; i < 5; i++) begin
            if (f[i] && en[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [15:0] exp_vec(input int n);
        return 16'h40 + 16'(n * 8);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_boundary(input bit ime, input logic [7:0] f, input logic [4:0] en,
                                input logic [15:0] pc, input logic [15:0] sp,
                                input logic [7:0] ic, input bit inject);
        int n;
        bit disp;
        n = exp_idx(f, en);
        disp = ime && (n >= 0);
        boundary = 1'b1; ime_in = ime; flags_in = f; enable_in = en;
        pc_in = pc; sp_in = sp; inst_cycles = ic;
        step();
        boundary = inject;
        flags_in = 8'h01; enable_in = 5'h1F; ime_in = 1'b1;
        pc_in = ~pc; sp_in = ~sp;
        // first cycle after boundary
        check("R10 total_valid", {31'd0, total_valid}, 32'd1);
        check("R10 total_cycles", {24'd0, total_cycles}, {24'd0, ic + (disp ? 8'd20 : 8'd0)});
        check("R9 busy first", {31'd0, busy}, {31'd0, disp});
        check("R5 flags_wr", {31'd0, flags_wr}, {31'd0, disp});
        check("R6 ime_clr", {31'd0, ime_clr}, {31'd0, disp});
        if (disp) begin
            check("R5 flags_out", {24'd0, flags_out}, {24'd0, f & ~(8'd1 << n)});
        end
        if (!disp) begin
            if (inject) begin
                boundary = 1'b0;
            end
            for (int k = 0; k < 3; k++) begin
                step();
                check(ime ? "R2 no entry busy" : "R1 no entry busy", {31'd0, busy}, 32'd0);
                check(ime ? "R2 no stack write" : "R1 no stack write",
                      {30'd0, stk_we, pc_ld}, 32'd0);
            end
            return;
        end
        step();
        boundary = 1'b0;
        check("R11 no report while busy", {31'd0, total_valid}, 32'd0);
        check("R9 busy gap", {31'd0, busy}, 32'd1);
        check("R7 gap idle bus", {29'd0, stk_we, sp_wr, pc_ld}, 32'd0);
        step();
        check("R7 push hi we", {31'd0, stk_we}, 32'd1);
        check("R7 push hi addr", {16'd0, stk_addr}, {16'd0, sp - 16'd1});
        check("R7 push hi data", {24'd0, stk_data}, {24'd0, pc[15:8]});
        step();
        check("R7 push lo we", {30'd0, stk_we, sp_wr}, 32'd3);
        check("R7 push lo addr", {16'd0, stk_addr}, {16'd0, sp - 16'd2});
        check("R7 push lo data", {24'd0, stk_data}, {24'd0, pc[7:0]});
        check("R7 sp out", {16'd0, sp_out}, {16'd0, sp - 16'd2});
        step();
        check("R8 pc_ld", {30'd0, pc_ld, busy}, 32'd3);
        check("R4 vector", {16'd0, pc_out}, {16'd0, exp_vec(n)});
        step();
        check("R9 busy ends", {30'd0, busy, pc_ld}, 32'd0);
        check("R11 no late report", {31'd0, total_valid}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset outputs",
              {24'd0, busy, flags_wr, ime_clr, stk_we, sp_wr, pc_ld, total_valid, 1'b0}, 32'd0);
        rst_n = 1'b1;
        step();
        check("R12 idle after reset", {31'd0, busy}, 32'd0);

        // R1 global enable clear with everything pending
        run_boundary(1'b0, 8'hFF, 5'h1F, 16'h1234, 16'hFFFE, 8'd4, 1'b0);
        // R2 only bits 5..7 pending
        run_boundary(1'b1, 8'hE0, 5'h1F, 16'h2000, 16'hC000, 8'd8, 1'b0);
        // R2 pending but masked
        run_boundary(1'b1, 8'h1F, 5'h00, 16'h2002, 16'hC000, 8'd12, 1'b0);
        // R3 all pending: bit 0 wins
        run_boundary(1'b1, 8'hFF, 5'h1F, 16'hABCD, 16'hDFF0, 8'd16, 1'b0);
        // R3 bit 4 only enabled among many
        run_boundary(1'b1, 8'h18, 5'h10, 16'h0150, 16'hFFFE, 8'd4, 1'b0);
        // R4 each source alone
        for (int s = 0; s < 5; s++) begin
            run_boundary(1'b1, 8'hE0 | (8'd1 << s), 5'h1F, 16'h4000 + 16'(s), 16'hD000, 8'd8, 1'b1);
        end
        // R7 stack pointer wrap
        run_boundary(1'b1, 8'h04, 5'h04, 16'h8899, 16'h0001, 8'd20, 1'b0);
        // R11 injected boundaries during busy
        run_boundary(1'b1, 8'h0A, 5'h0A, 16'h7F7F, 16'h9000, 8'd24, 1'b1);

        for (int it = 0; it < 80; it++) begin
            run_boundary(($urandom % 4) != 0, 8'($urandom), 5'($urandom),
                         16'($urandom), 16'($urandom), 8'(4 * (1 + ($urandom % 6))),
                         ($urandom % 3) == 0);
        end
        finish_run();
    end

endmodule